// File: doc/BRIEF.md
# SDLC Bit-Stuffing Transmit Framer

This block turns characters from a one-entry holding register into a bit-oriented synchronous serial stream. With the transmitter switched on and nothing to send, it repeats the 8-bit flag pattern. When characters arrive, they are shifted out least-significant bit first. Each character is 1 to 8 bits long. The length is captured at the moment a character leaves the holding register. A zero is inserted after every run of five ones in character and check bits. When the holding register runs dry, the frame is closed automatically. Depending on a control input, the close is either a 16-bit frame check sequence and a flag, or a flag alone.

An abort command can be issued at any time. It discards both the character in flight and the held character, sends a run of eight unstuffed ones, and then returns to flags. All output changes happen on a one-cycle bit-time enable, which marks the transmit clock edge on which data is launched. The surrounding logic writes characters whenever `hold_empty` is high. Before the first character of each frame, it issues a check-register clear.

Top module: `sdlc_tx_framer`

## Requirements
- R1: After the synchronous reset, `tx_bit` is 1 and `hold_empty` is 1. The check register holds all ones.
- R2: While `tx_enable` is low, every bit time drives `tx_bit` to 1. While it is high and no character is available, the output repeats the flag 0x7E, least-significant bit first (bit order 0,1,1,1,1,1,1,0).
- R3: If a character is already held when the transmitter is switched on, the first bit time sends that character's bit 0, with no opening flag.
- R4: Characters go out least-significant bit first, using the low `char_len` bits, and the upper bits are ignored. A `char_len` of 1 to 8 gives that many bits. A value of 0 or above 8 gives 8 bits.
- R5: The length is sampled when a character moves from the holding register into the shifter. A change of `char_len` therefore applies to the held character but not to the one being shifted.
- R6: After five consecutive ones among character and check bits, one 0 is inserted, including just before a closing flag. Flag and abort bits are never stuffed and reset the run.
- R7: The check sequence uses the reflected CCITT polynomial (x^16+x^12+x^5+1, LSB first, preset all ones by `crc_clear` or reset). It covers only character bits and is sent complemented, least-significant bit first. For the characters "123456789", the bits sent equal 0x906E.
- R8: When the shifter empties with no held character after character data, `eom_crc`=1 sends the 16 check bits followed by flags, and `eom_crc`=0 sends flags directly.
- R9: A pulse on `abort_cmd` while enabled makes the next bit time start eight ones, followed by flags. The in-flight character and the held character are both discarded, so `hold_empty` is 1 afterwards. A run of ones on the line never exceeds 13.
- R10: `hold_empty` falls in the cycle after `wr_en`. It rises only at a bit time, when the character is taken or discarded.
- R11: `tx_bit` changes only in the cycle after `bit_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle pulse per transmit bit time |
| tx_enable | input | 1 | Transmitter on |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character, right-justified |
| char_len | input | 4 | Bits per character (0 means 8) |
| crc_clear | input | 1 | Preset the check register to all ones |
| abort_cmd | input | 1 | Request an abort sequence |
| eom_crc | input | 1 | 1: close on underrun with check bits and flag; 0: flag only |
| tx_bit | output | 1 | Serial data out |
| hold_empty | output | 1 | Holding register can take a character |

## Verification
The bench drives long runs of ones, so that a stuffer that counts flag bits, forgets the run across character boundaries, or misses the zero before the closing flag produces a shifted stream. It also cuts into a run of five data ones with an abort: a design that stuffs the abort, or keeps the held character, shows a run other than thirteen or leaks data after the abort. The length is changed while a character is mid-shift, which exposes a design that samples the length at write time or per bit. A known nine-character frame catches a wrong polynomial, bit order or final inversion in the check sequence.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;

  // What the shifter is currently sending
  typedef enum logic [2:0] {
    UNIT_IDLE,
    UNIT_FLAG,
    UNIT_DATA,
    UNIT_FCS,
    UNIT_ABORT
  } unit_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdlc_tx_hold.sv
// One-entry character holding register; a write wins over take/discard.
module sdlc_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  input  logic          drop,
  output logic [DW-1:0] data,
  output logic          full
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      full <= 1'b0;
    end else if (wr_en) begin
      data <= wr_data;
      full <= 1'b1;
    end else if (take || drop) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/sdlc_tx_fcs.sv
// Bit-serial reflected CRC register, LSB-first input.
module sdlc_tx_fcs #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'h8408
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] crc
);

  logic         fb;
  logic [W-1:0] crc_next;

  assign fb       = crc[0] ^ din;
  assign crc_next = (crc >> 1) ^ (fb ? POLY : '0);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      crc <= '1;
    end else if (step) begin
      crc <= crc_next;
    end
  end

endmodule

// File: rtl/sdlc_tx_stuff.sv
// Counts consecutive stuffable ones on the line; flags when a zero is due.
module sdlc_tx_stuff #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic one_stuffable,
  output logic need_zero
);

  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= one_stuffable ? cnt + 1'b1 : '0;
    end
  end

  assign need_zero = (cnt == CW'(RUN));

endmodule

// File: rtl/sdlc_tx_framer.sv
module sdlc_tx_framer
  import sdlc_tx_pkg::*;
#(
  parameter int DW        = 8,
  parameter int LEN_W     = 4,
  parameter int FCS_W     = 16,
  parameter int FLAG_W    = 8,
  parameter int ABORT_W   = 8,
  parameter int STUFF_RUN = 5,
  parameter logic [FCS_W-1:0]  FCS_POLY = 16'h8408,
  parameter logic [FLAG_W-1:0] FLAG_PAT = 8'h7E
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             tx_enable,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic [LEN_W-1:0] char_len,
  input  logic             crc_clear,
  input  logic             abort_cmd,
  input  logic             eom_crc,
  output logic             tx_bit,
  output logic             hold_empty
);

  localparam int SH_W  = max2(max2(DW, FCS_W), max2(FLAG_W, ABORT_W));
  localparam int CNT_W = $clog2(SH_W + 1);

  // Registered state
  unit_e              unit_q;
  logic [SH_W-1:0]    sh_q;
  logic [CNT_W-1:0]   left_q;
  logic               open_q;
  logic               abort_q;
  logic               tx_q;

  // Submodule interconnect
  logic [DW-1:0]      hold_data;
  logic               hold_full;
  logic [FCS_W-1:0]   crc;
  logic               need_zero;

  // Next-step decisions
  unit_e              ld_unit, nxt_unit;
  logic [SH_W-1:0]    ld_sh, nxt_sh;
  logic [CNT_W-1:0]   ld_len, nxt_left, eff_len;
  logic               nxt_open;
  logic               emit_bit, emit_stuffable;
  logic               crc_step, take, drop, do_abort;

  sdlc_tx_hold #(.DW(DW)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (bit_en & take),
    .drop    (bit_en & drop),
    .data    (hold_data),
    .full    (hold_full)
  );

  sdlc_tx_fcs #(.W(FCS_W), .POLY(FCS_POLY)) u_fcs (
    .clk   (clk),
    .rst   (rst),
    .clear (crc_clear),
    .step  (bit_en & crc_step),
    .din   (emit_bit),
    .crc   (crc)
  );

  sdlc_tx_stuff #(.RUN(STUFF_RUN)) u_stuff (
    .clk           (clk),
    .rst           (rst),
    .adv           (bit_en),
    .one_stuffable (emit_stuffable & emit_bit),
    .need_zero     (need_zero)
  );

  // Effective length: out-of-range codes fall back to a full character
  always_comb begin
    if (char_len == '0 || char_len > LEN_W'(DW)) begin
      eff_len = CNT_W'(DW);
    end else begin
      eff_len = CNT_W'(char_len);
    end
  end

  // Unit chosen when the shifter is empty
  always_comb begin
    if (hold_full) begin
      ld_unit = UNIT_DATA;
      ld_sh   = SH_W'(hold_data);
      ld_len  = eff_len;
    end else if (open_q && eom_crc) begin
      ld_unit = UNIT_FCS;
      ld_sh   = SH_W'(~crc);
      ld_len  = CNT_W'(FCS_W);
    end else begin
      ld_unit = UNIT_FLAG;
      ld_sh   = SH_W'(FLAG_PAT);
      ld_len  = CNT_W'(FLAG_W);
    end
  end

  assign do_abort = abort_q | abort_cmd;

  // Per-bit-time step: disable > abort > stuffed zero > continue > load
  always_comb begin
    nxt_unit       = unit_q;
    nxt_sh         = sh_q;
    nxt_left       = left_q;
    nxt_open       = open_q;
    emit_bit       = tx_q;
    emit_stuffable = 1'b0;
    crc_step       = 1'b0;
    take           = 1'b0;
    drop           = 1'b0;
    if (!tx_enable) begin
      emit_bit = 1'b1;
      nxt_unit = UNIT_IDLE;
      nxt_left = '0;
      nxt_open = 1'b0;
    end else if (do_abort) begin
      emit_bit = 1'b1;
      nxt_unit = UNIT_ABORT;
      nxt_sh   = '1;
      nxt_left = CNT_W'(ABORT_W - 1);
      nxt_open = 1'b0;
      drop     = 1'b1;
    end else if (need_zero) begin
      emit_bit = 1'b0;
    end else if (left_q != '0) begin
      emit_bit       = sh_q[0];
      nxt_sh         = sh_q >> 1;
      nxt_left       = left_q - 1'b1;
      emit_stuffable = (unit_q == UNIT_DATA) || (unit_q == UNIT_FCS);
      crc_step       = (unit_q == UNIT_DATA);
    end else begin
      emit_bit       = ld_sh[0];
      nxt_sh         = ld_sh >> 1;
      nxt_left       = ld_len - 1'b1;
      nxt_unit       = ld_unit;
      emit_stuffable = (ld_unit == UNIT_DATA) || (ld_unit == UNIT_FCS);
      crc_step       = (ld_unit == UNIT_DATA);
      take           = (ld_unit == UNIT_DATA);
      nxt_open       = (ld_unit == UNIT_DATA);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unit_q <= UNIT_IDLE;
      sh_q   <= '0;
      left_q <= '0;
      open_q <= 1'b0;
      tx_q   <= 1'b1;
    end else if (bit_en) begin
      unit_q <= nxt_unit;
      sh_q   <= nxt_sh;
      left_q <= nxt_left;
      open_q <= nxt_open;
      tx_q   <= emit_bit;
    end
  end

  // Abort request waits for the next bit time; dropped when disabled
  always_ff @(posedge clk) begin
    if (rst || !tx_enable || bit_en) begin
      abort_q <= 1'b0;
    end else if (abort_cmd) begin
      abort_q <= 1'b1;
    end
  end

  assign tx_bit     = tx_q;
  assign hold_empty = ~hold_full;

endmodule

// File: rtl/sdlc_tx_framer_chk.sv
module sdlc_tx_framer_chk #(
  parameter int MAX_RUN = 13
) (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic tx_enable,
  input logic wr_en,
  input logic tx_bit,
  input logic hold_empty
);

  logic [4:0] run_q;
  logic       tick_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      tick_d <= 1'b0;
    end else begin
      tick_d <= bit_en;
      if (!tx_enable) begin
        run_q <= '0;
      end else if (tick_d) begin
        run_q <= tx_bit ? ((run_q == 5'd31) ? run_q : run_q + 1'b1) : '0;
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tx_bit && hold_empty));

  assert_disabled_mark_R2: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !tx_enable) |=> tx_bit);

  assert_ones_run_R9: assert property (@(posedge clk) disable iff (rst)
    run_q <= 5'(MAX_RUN));

  assert_write_fills_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !hold_empty);

  assert_empty_on_tick_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_empty) |-> $past(bit_en));

  assert_change_on_tick_R11: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(tx_bit));

endmodule

bind sdlc_tx_framer sdlc_tx_framer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_en     (bit_en),
  .tx_enable  (tx_enable),
  .wr_en      (wr_en),
  .tx_bit     (tx_bit),
  .hold_empty (hold_empty)
);

// File: tb/sim_sdlc_tx_framer.sv
`timescale 1ns/1ps
module sim_sdlc_tx_framer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       tx_enable = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [3:0] char_len = 4'd8;
  logic       crc_clear = 1'b0;
  logic       abort_cmd = 1'b0;
  logic       eom_crc = 1'b1;
  logic       tx_bit;
  logic       hold_empty;

  int          n_chk = 0;
  int          n_fail = 0;
  bit          exp_q[$];
  logic [7:0]  feed_q[$];
  int          ones_m = 0;
  logic [15:0] crc_m = 16'hFFFF;

  always #4 clk = ~clk;

  sdlc_tx_framer u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .tx_enable(tx_enable),
    .wr_en(wr_en), .wr_data(wr_data), .char_len(char_len),
    .crc_clear(crc_clear), .abort_cmd(abort_cmd), .eom_crc(eom_crc),
    .tx_bit(tx_bit), .hold_empty(hold_empty)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model of the line ----------------
  task automatic m_reset();
    exp_q.delete();
    feed_q.delete();
    ones_m = 0;
    crc_m  = 16'hFFFF;
  endtask

  task automatic m_stuffed(input bit b);
    if (ones_m == 5) begin exp_q.push_back(1'b0); ones_m = 0; end
    exp_q.push_back(b);
    ones_m = b ? ones_m + 1 : 0;
  endtask

  task automatic m_flag();
    logic [7:0] f = 8'h7E;
    if (ones_m == 5) exp_q.push_back(1'b0);
    for (int i = 0; i < 8; i++) exp_q.push_back(f[i]);
    ones_m = 0;
  endtask

  task automatic m_abort();
    for (int i = 0; i < 8; i++) exp_q.push_back(1'b1);
    ones_m = 0;
  endtask

  task automatic m_char(input logic [7:0] d, input int len);
    for (int i = 0; i < len; i++) begin
      bit fb = crc_m[0] ^ d[i];
      crc_m = (crc_m >> 1) ^ (fb ? 16'h8408 : 16'h0000);
      m_stuffed(d[i]);
    end
  endtask

  task automatic m_fcs();
    logic [15:0] f = ~crc_m;
    for (int i = 0; i < 16; i++) m_stuffed(f[i]);
  endtask

  // ---------------- drivers (all entered at a negedge) ----------------
  task automatic do_reset();
    rst = 1'b1; bit_en = 0; tx_enable = 0; wr_en = 0; crc_clear = 0;
    abort_cmd = 0; eom_crc = 1; char_len = 4'd8;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    m_reset();
  endtask

  task automatic tick(output logic b);
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    b = tx_bit;
  endtask

  task automatic write_char(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_crc();
    crc_clear = 1'b1;
    @(negedge clk);
    crc_clear = 1'b0;
  endtask

  task automatic send_abort();
    abort_cmd = 1'b1;
    @(negedge clk);
    abort_cmd = 1'b0;
  endtask

  task automatic stream_check(input string req, input int n);
    int   bad = 0;
    int   first = -1;
    logic a0 = 1'b0;
    logic e0 = 1'b0;
    logic b;
    bit   e;
    for (int i = 0; i < n; i++) begin
      tick(b);
      if (hold_empty && feed_q.size() > 0) write_char(feed_q.pop_front());
      e = exp_q.pop_front();
      if (b !== e) begin
        bad++;
        if (first < 0) begin first = i; a0 = b; e0 = e; end
      end
    end
    check(bad == 0, req, $sformatf("stream of %0d bits, first bad index %0d", n, first), a0, e0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    do_reset();
    check(tx_bit == 1'b1, "R1", "tx_bit after reset", tx_bit, 1);
    check(hold_empty == 1'b1, "R1", "hold_empty after reset", hold_empty, 1);
  endtask

  task automatic t_idle();
    logic b;
    int   zeros = 0;
    do_reset();
    for (int i = 0; i < 10; i++) begin tick(b); if (b !== 1'b1) zeros++; end
    check(zeros == 0, "R2", "disabled line bits not one", zeros, 0);
    tx_enable = 1'b1;
    for (int i = 0; i < 3; i++) m_flag();
    stream_check("R2 idle flags", exp_q.size());
    tx_enable = 1'b0;
    zeros = 0;
    for (int i = 0; i < 4; i++) begin tick(b); if (b !== 1'b1) zeros++; end
    check(zeros == 0, "R2", "line after disable not one", zeros, 0);
  endtask

  task automatic t_frame_crc();
    logic [15:0] fcs;
    do_reset();
    eom_crc = 1'b1;
    clear_crc();
    write_char(8'h31);
    check(hold_empty == 1'b0, "R10", "hold_empty after write", hold_empty, 0);
    for (int i = 2; i <= 9; i++) feed_q.push_back(8'h30 + 8'(i));
    for (int i = 1; i <= 9; i++) m_char(8'h30 + 8'(i), 8);
    fcs = ~crc_m;
    check(fcs == 16'h906E, "R7", "reference check value", fcs, 16'h906E);
    m_fcs();
    m_flag(); m_flag();
    tx_enable = 1'b1;
    stream_check("R3 R7 R8 frame with check bits", exp_q.size());
    // second frame, back to back, heavy in ones
    clear_crc();
    crc_m = 16'hFFFF;
    write_char(8'hFF);
    feed_q.push_back(8'hFF);
    feed_q.push_back(8'h7E);
    m_char(8'hFF, 8); m_char(8'hFF, 8); m_char(8'h7E, 8);
    m_fcs();
    m_flag(); m_flag();
    stream_check("R6 R7 stuffed frame after clear", exp_q.size());
  endtask

  task automatic t_flag_close();
    do_reset();
    eom_crc = 1'b0;
    write_char(8'h3E);
    feed_q.push_back(8'hA5);
    m_char(8'h3E, 8); m_char(8'hA5, 8);
    m_flag(); m_flag();
    tx_enable = 1'b1;
    stream_check("R8 flag-only close", exp_q.size());
  endtask

  task automatic t_length();
    do_reset();
    eom_crc = 1'b1;
    char_len = 4'd8;
    write_char(8'hC3);
    tx_enable = 1'b1;
    m_char(8'hC3, 8);
    m_char(8'hFD, 3);
    m_fcs();
    m_flag(); m_flag();
    stream_check("R5 first bit", 1);
    write_char(8'hFD);
    char_len = 4'd3;
    stream_check("R4 R5 length change mid-shift", exp_q.size());
  endtask

  task automatic t_len_extremes();
    logic [7:0] seq [8] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hAA, 8'hFF};
    do_reset();
    eom_crc = 1'b0;
    char_len = 4'd1;
    write_char(seq[0]);
    for (int i = 1; i < 8; i++) feed_q.push_back(seq[i]);
    for (int i = 0; i < 8; i++) m_char(seq[i], 1);
    m_flag(); m_flag();
    tx_enable = 1'b1;
    stream_check("R4 R6 one-bit characters", exp_q.size());
    char_len = 4'd0;
    write_char(8'h81);
    feed_q.push_back(8'h55);
    m_char(8'h81, 8); m_char(8'h55, 8);
    m_flag();
    stream_check("R4 length code zero means eight", exp_q.size());
  endtask

  task automatic t_abort();
    do_reset();
    eom_crc = 1'b1;
    write_char(8'hFF);
    feed_q.push_back(8'hFF);
    tx_enable = 1'b1;
    for (int i = 0; i < 5; i++) m_stuffed(1'b1);
    stream_check("R9 ones before abort", 5);
    check(hold_empty == 1'b0, "R9", "second character held", hold_empty, 0);
    send_abort();
    m_abort();
    m_flag(); m_flag(); m_flag();
    stream_check("R9 abort run then flags", exp_q.size());
    check(hold_empty == 1'b1, "R9", "held character discarded", hold_empty, 1);
  endtask

  initial begin
    #(8 * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    t_frame_crc();
    t_flag_close();
    t_length();
    t_len_extremes();
    t_abort();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule